// File: doc/BRIEF.md
# CAN Mailbox Time-Out Status Controller

This block watches the mailboxes of a 32-mailbox CAN controller for communication time-outs. Each mailbox has a CPU-owned time-out enable bit. When the time-stamp logic reports a time-out for an enabled mailbox, the block sets that mailbox's status bit. It also raises the global flag of the interrupt line the mailbox is routed to. A per-mailbox line-select bit picks line 0 or line 1. A rising global flag emits a one-cycle interrupt pulse. That pulse is captured in a pending latch, which holds it until the CPU acknowledges it.

The status bits clear themselves. A late successful transfer on a mailbox clears its status bit. Clearing the mailbox's time-out enable bit also clears it. In both cases the global flag drops once no status bit remains on its line. The CPU can also clear a global flag directly. The pending latch is not cleared by any of these, so a handler may find a pending interrupt with no flag set behind it (a phantom interrupt).

The block mirrors the protocol engine's transmit-busy and receive-busy signals as status bits. It also holds the identifier word of every mailbox. The CPU can write a mailbox's identifier only while that mailbox is disabled.

Top module: `mbxTimeoutCtl`

## Requirements
- R1: A time-out pulse on mailbox n whose enable bit is 1 sets status bit n and the global flag of n's line after the next clock edge. The same edge produces a one-cycle interrupt pulse on that line and sets that line's pending bit.
- R2: A time-out pulse on a mailbox whose enable bit is 0 changes no status bit, flag, pulse or pending bit, and a status bit is never 1 while its enable bit is 0.
- R3: A transfer-done pulse on mailbox n clears status bit n at the next edge. A global flag clears at that edge when no status bit routed to its line remains set.
- R4: A write of the enable register that takes bit n from 1 to 0 clears status bit n at the same edge. The flag of its line then drops as in R3.
- R5: A flag-clear write with mask bit l set clears global flag l at the next edge, even while status bits on line l stay set. A later time-out on line l sets the flag again and issues a new pulse.
- R6: The interrupt pulse lasts one cycle. The pending bit stays 1 until an acknowledge on its line, even after the status bits and flag clear on their own (phantom interrupt). A new pulse on the acknowledge cycle wins.
- R7: A time-out and a transfer-done on the same mailbox in the same cycle leave the status bit cleared. The line still gets exactly one interrupt pulse and its pending bit.
- R8: Line-select bit n equal to 0 routes mailbox n to line 0; equal to 1 routes it to line 1.
- R9: The transmit-active and receive-active outputs equal the engine's busy inputs one clock edge later.
- R10: An identifier write to mailbox n lands only while mailbox-enable bit n is 0 and is ignored otherwise. In the stored word, bit 31 is the extended-ID flag, bit 30 is the mask enable, bit 29 is auto-answer, and bits 28:0 are the identifier. The read port shows these fields for the addressed mailbox.
- R11: After reset all status bits, enable bits, line-select bits, flags, pulses, pending bits, activity bits and stored identifiers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| toEvent | input | NUM_MBX | Per-mailbox time-out pulse |
| xferDone | input | NUM_MBX | Per-mailbox successful transfer pulse |
| tocWrEn | input | 1 | Write strobe for time-out enable register |
| tocWrData | input | NUM_MBX | New time-out enable bits |
| lvlWrEn | input | 1 | Write strobe for line-select register |
| lvlWrData | input | NUM_MBX | New line-select bits |
| flagClrEn | input | 1 | Strobe for direct global flag clear |
| flagClrMask | input | 2 | Lines whose flag is cleared |
| irqAck | input | 2 | Acknowledge of pending interrupt per line |
| engTxBusy | input | 1 | Protocol engine is transmitting |
| engRxBusy | input | 1 | Protocol engine is receiving |
| mbxEnable | input | NUM_MBX | Mailbox enable vector |
| idWrEn | input | 1 | Identifier write strobe |
| idWrIdx | input | IDX_W | Mailbox addressed by the write |
| idWrData | input | 32 | Identifier word to write |
| idRdIdx | input | IDX_W | Mailbox addressed by the read |
| tosStatus | output | NUM_MBX | Per-mailbox time-out status |
| toFlag | output | 2 | Global time-out flag per line |
| irqPulse | output | 2 | One-cycle interrupt request per line |
| irqPend | output | 2 | Pending interrupt per line |
| txActive | output | 1 | Transmit in progress |
| rxActive | output | 1 | Receive in progress |
| rdExtId | output | 1 | Extended-ID flag of the read mailbox |
| rdMaskEn | output | 1 | Mask enable of the read mailbox |
| rdAutoAns | output | 1 | Auto-answer bit of the read mailbox |
| rdIdent | output | 29 | Identifier of the read mailbox |

## Verification
Status, flags, interrupt pulses, pending bits and activity bits are all registered, so each is due at the first clock edge after the cycle its stimulus is applied. The identifier fields come from a combinational read of registered storage, so a write shows on the read port after that same edge. The bench applies one stimulus per cycle at the falling edge. It queues the full expected output picture for the coming rising edge, and the monitor compares it 2 ns after that edge. This way a late or early update in any field is caught in the cycle it happens.

// File: rtl/canTmoPkg.sv
package canTmoPkg;
  localparam int LINES  = 2;
  localparam int WORD_W = 32;

  // stored identifier word, MSB first
  typedef struct packed {
    logic        extId;
    logic        maskEn;
    logic        autoAns;
    logic [28:0] ident;
  } mbxIdT;

  // strobes from control to datapath
  typedef struct packed {
    logic [LINES-1:0] lineSet;
    logic [LINES-1:0] cpuClr;
    logic             idWrOk;
  } tmoStrobeT;
endpackage

// File: rtl/mbxTmoCtrl.sv
module mbxTmoCtrl
  import canTmoPkg::*;
#(
  parameter int NUM_MBX = 32,
  localparam int IDX_W = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_MBX-1:0] toEvent,
  input  logic [NUM_MBX-1:0] xferDone,
  input  logic               tocWrEn,
  input  logic [NUM_MBX-1:0] tocWrData,
  input  logic               lvlWrEn,
  input  logic [NUM_MBX-1:0] lvlWrData,
  input  logic               flagClrEn,
  input  logic [LINES-1:0]   flagClrMask,
  input  logic               idWrEn,
  input  logic [IDX_W-1:0]   idWrIdx,
  input  logic [NUM_MBX-1:0] mbxEnable,
  output logic [NUM_MBX-1:0] toc,
  output logic [NUM_MBX-1:0] lvl,
  output logic [NUM_MBX-1:0] setTos,
  output logic [NUM_MBX-1:0] clrTos,
  output tmoStrobeT          strobe
);
  logic [NUM_MBX-1:0] liveEvent;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toc <= '0;
      lvl <= '0;
    end else begin
      if (tocWrEn) toc <= tocWrData;
      if (lvlWrEn) lvl <= lvlWrData;
    end
  end

  // events only count on enabled mailboxes; success outranks a time-out
  assign liveEvent = toEvent & toc;
  assign setTos    = liveEvent & ~xferDone;
  assign clrTos    = xferDone | (tocWrEn ? ~tocWrData : '0);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [NUM_MBX-1:0] lineMask;
    assign lineMask          = (g == 0) ? ~lvl : lvl;
    assign strobe.lineSet[g] = |(liveEvent & lineMask);
  end

  assign strobe.cpuClr = flagClrEn ? flagClrMask : '0;
  assign strobe.idWrOk = idWrEn & ~mbxEnable[idWrIdx];
endmodule

// File: rtl/mbxTmoData.sv
module mbxTmoData
  import canTmoPkg::*;
#(
  parameter int NUM_MBX = 32,
  localparam int IDX_W = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_MBX-1:0] setTos,
  input  logic [NUM_MBX-1:0] clrTos,
  input  logic [NUM_MBX-1:0] lvl,
  input  tmoStrobeT          strobe,
  input  logic [LINES-1:0]   irqAck,
  input  logic               engTxBusy,
  input  logic               engRxBusy,
  input  logic [IDX_W-1:0]   idWrIdx,
  input  logic [WORD_W-1:0]  idWrData,
  input  logic [IDX_W-1:0]   idRdIdx,
  output logic [NUM_MBX-1:0] tos,
  output logic [LINES-1:0]   flag,
  output logic [LINES-1:0]   irqPulse,
  output logic [LINES-1:0]   irqPend,
  output logic               txActive,
  output logic               rxActive,
  output mbxIdT              idRd
);
  logic [NUM_MBX-1:0] tosNext;
  logic [LINES-1:0]   flagNext;
  logic [LINES-1:0]   riseNext;
  logic [WORD_W-1:0]  idMem [NUM_MBX];

  assign tosNext = (tos | setTos) & ~clrTos;

  for (genvar g = 0; g < LINES; g++) begin : g_flag
    logic [NUM_MBX-1:0] lineMask;
    assign lineMask    = (g == 0) ? ~lvl : lvl;
    // flag survives only while some status bit on its line survives
    assign flagNext[g] = strobe.lineSet[g]
                       | (flag[g] & ~strobe.cpuClr[g] & (|(tosNext & lineMask)));

    p_flag_rise_irq_r1: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flag[g]) |-> irqPulse[g]);
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse[g] |=> !irqPulse[g]);
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (irqPend[g] && !irqAck[g]) |=> irqPend[g]);
  end

  assign riseNext = flagNext & ~flag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tos      <= '0;
      flag     <= '0;
      irqPulse <= '0;
      irqPend  <= '0;
      txActive <= 1'b0;
      rxActive <= 1'b0;
      for (int i = 0; i < NUM_MBX; i++) idMem[i] <= '0;
    end else begin
      tos      <= tosNext;
      flag     <= flagNext;
      irqPulse <= riseNext;
      irqPend  <= (irqPend & ~irqAck) | riseNext;
      txActive <= engTxBusy;
      rxActive <= engRxBusy;
      if (strobe.idWrOk) idMem[idWrIdx] <= idWrData;
    end
  end

  assign idRd = mbxIdT'(idMem[idRdIdx]);

  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrTos != '0) |=> ((tos & $past(clrTos)) == '0));
endmodule

// File: rtl/mbxTimeoutCtl.sv
module mbxTimeoutCtl
  import canTmoPkg::*;
#(
  parameter int NUM_MBX = 32,
  localparam int IDX_W = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_MBX-1:0] toEvent,
  input  logic [NUM_MBX-1:0] xferDone,
  input  logic               tocWrEn,
  input  logic [NUM_MBX-1:0] tocWrData,
  input  logic               lvlWrEn,
  input  logic [NUM_MBX-1:0] lvlWrData,
  input  logic               flagClrEn,
  input  logic [1:0]         flagClrMask,
  input  logic [1:0]         irqAck,
  input  logic               engTxBusy,
  input  logic               engRxBusy,
  input  logic [NUM_MBX-1:0] mbxEnable,
  input  logic               idWrEn,
  input  logic [IDX_W-1:0]   idWrIdx,
  input  logic [31:0]        idWrData,
  input  logic [IDX_W-1:0]   idRdIdx,
  output logic [NUM_MBX-1:0] tosStatus,
  output logic [1:0]         toFlag,
  output logic [1:0]         irqPulse,
  output logic [1:0]         irqPend,
  output logic               txActive,
  output logic               rxActive,
  output logic               rdExtId,
  output logic               rdMaskEn,
  output logic               rdAutoAns,
  output logic [28:0]        rdIdent
);
  logic [NUM_MBX-1:0] toc, lvl, setTos, clrTos;
  tmoStrobeT          strobe;
  mbxIdT              idRd;

  mbxTmoCtrl #(.NUM_MBX(NUM_MBX)) ctrl_i (
    .clk(clk), .rstN(rstN), .toEvent(toEvent), .xferDone(xferDone),
    .tocWrEn(tocWrEn), .tocWrData(tocWrData), .lvlWrEn(lvlWrEn),
    .lvlWrData(lvlWrData), .flagClrEn(flagClrEn), .flagClrMask(flagClrMask),
    .idWrEn(idWrEn), .idWrIdx(idWrIdx), .mbxEnable(mbxEnable),
    .toc(toc), .lvl(lvl), .setTos(setTos), .clrTos(clrTos), .strobe(strobe)
  );

  mbxTmoData #(.NUM_MBX(NUM_MBX)) data_i (
    .clk(clk), .rstN(rstN), .setTos(setTos), .clrTos(clrTos), .lvl(lvl),
    .strobe(strobe), .irqAck(irqAck), .engTxBusy(engTxBusy),
    .engRxBusy(engRxBusy), .idWrIdx(idWrIdx), .idWrData(idWrData),
    .idRdIdx(idRdIdx), .tos(tosStatus), .flag(toFlag), .irqPulse(irqPulse),
    .irqPend(irqPend), .txActive(txActive), .rxActive(rxActive), .idRd(idRd)
  );

  assign rdExtId   = idRd.extId;
  assign rdMaskEn  = idRd.maskEn;
  assign rdAutoAns = idRd.autoAns;
  assign rdIdent   = idRd.ident;

  p_tos_needs_toc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tosStatus & ~toc) == '0);
endmodule

// File: tb/mbxTimeoutCtl_tb_top.sv
module mbxTimeoutCtl_tb_top;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] toEvent = '0, xferDone = '0, tocWrData = '0, lvlWrData = '0, mbxEnable = '0;
  logic tocWrEn = 0, lvlWrEn = 0, flagClrEn = 0, engTxBusy = 0, engRxBusy = 0, idWrEn = 0;
  logic [1:0] flagClrMask = '0, irqAck = '0;
  logic [4:0] idWrIdx = '0, idRdIdx = '0;
  logic [31:0] idWrData = '0;
  logic [N-1:0] tosStatus;
  logic [1:0] toFlag, irqPulse, irqPend;
  logic txActive, rxActive, rdExtId, rdMaskEn, rdAutoAns;
  logic [28:0] rdIdent;

  mbxTimeoutCtl dut_i (.*);

  typedef struct {
    int          req;
    logic [N-1:0] tos;
    logic [1:0]  flag, irq, pend;
    logic        tx, rx;
    logic [31:0] rd;
  } expT;

  expT q[$];
  int checks = 0, errors = 0;

  // reference state, from the requirements
  logic [N-1:0] mToc = '0, mTos = '0, mLvl = '0;
  logic [1:0]   mFlag = '0, mPend = '0;
  logic [31:0]  mId [N];

  // staged stimulus, applied by step()
  logic [N-1:0] sEv = '0, sDone = '0, sTocData = '0, sLvlData = '0, sEn = '0;
  logic sTocWr = 0, sLvlWr = 0, sClrEn = 0, sTx = 0, sRx = 0, sIdWr = 0;
  logic [1:0] sClrMask = '0, sAck = '0;
  logic [4:0] sIdx = '0, sRdIdx = '0;
  logic [31:0] sData = '0;

  task automatic step(input int req);
    expT e;
    logic [N-1:0] tosN, mask;
    logic [1:0] lineEv, anyN, flagN, rise;
    @(negedge clk);
    toEvent = sEv; xferDone = sDone; tocWrEn = sTocWr; tocWrData = sTocData;
    lvlWrEn = sLvlWr; lvlWrData = sLvlData; flagClrEn = sClrEn; flagClrMask = sClrMask;
    irqAck = sAck; engTxBusy = sTx; engRxBusy = sRx; mbxEnable = sEn;
    idWrEn = sIdWr; idWrIdx = sIdx; idWrData = sData; idRdIdx = sRdIdx;
    tosN = (mTos | (sEv & mToc & ~sDone)) & ~(sDone | (sTocWr ? ~sTocData : '0));
    for (int l = 0; l < 2; l++) begin
      mask = (l == 0) ? ~mLvl : mLvl;
      lineEv[l] = |(sEv & mToc & mask);
      anyN[l] = |(tosN & mask);
      flagN[l] = lineEv[l] | (mFlag[l] & ~(sClrEn & sClrMask[l]) & anyN[l]);
    end
    rise = flagN & ~mFlag;
    mPend = (mPend & ~sAck) | rise;
    mFlag = flagN;
    mTos = tosN;
    if (sTocWr) mToc = sTocData;
    if (sLvlWr) mLvl = sLvlData;
    if (sIdWr && !sEn[sIdx]) mId[sIdx] = sData;
    e.req = req; e.tos = mTos; e.flag = mFlag; e.irq = rise; e.pend = mPend;
    e.tx = sTx; e.rx = sRx; e.rd = mId[sRdIdx];
    q.push_back(e);
    sEv = '0; sDone = '0; sTocWr = 0; sLvlWr = 0; sClrEn = 0; sAck = '0; sIdWr = 0;
  endtask

  // monitor: compare one item per rising edge
  initial begin
    expT e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (tosStatus !== e.tos || toFlag !== e.flag || irqPulse !== e.irq ||
            irqPend !== e.pend || txActive !== e.tx || rxActive !== e.rx ||
            {rdExtId, rdMaskEn, rdAutoAns, rdIdent} !== e.rd) begin
          errors++;
          $display("FAIL R%0d: tos=%h flag=%b irq=%b pend=%b tx=%b rx=%b rd=%h | exp tos=%h flag=%b irq=%b pend=%b tx=%b rx=%b rd=%h",
                   e.req, tosStatus, toFlag, irqPulse, irqPend, txActive, rxActive,
                   {rdExtId, rdMaskEn, rdAutoAns, rdIdent},
                   e.tos, e.flag, e.irq, e.pend, e.tx, e.rx, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mId[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    step(11);                                           // R11 reset picture
    sTocWr = 1; sTocData = 32'h0000_00FF; step(4);      // enable mailboxes 0..7
    sEv = 32'h4; step(1);                               // R1 set, pulse, pending
    step(6);                                            // R6 pulse gone, pending held
    sEv = 32'h0010_0000; step(2);                       // R2 disabled mailbox ignored
    sDone = 32'h4; step(3);                             // R3 late success, phantom pending
    step(6);
    sAck = 2'b01; step(6);                              // R6 acknowledge
    sLvlWr = 1; sLvlData = 32'h20; step(8);             // R8 mailbox 5 to line 1
    sEv = 32'h20; step(8);                              // R8 line 1 rises only
    sEv = 32'h8; sDone = 32'h8; step(7);                // R7 same-cycle collision
    step(7);                                            // R7 flag falls, one pulse
    sTocWr = 1; sTocData = 32'h0000_00DF; step(4);      // R4 clear enable of mailbox 5
    sAck = 2'b11; step(6);
    sEv = 32'h2; step(5);
    sClrEn = 1; sClrMask = 2'b01; step(5);              // R5 direct clear, status stays
    sEv = 32'h1; step(5);                               // R5 new rise
    sEv = 32'h1; step(1);                               // R1 flag already high: no new pulse
    sTx = 1; step(9);                                   // R9
    sTx = 0; sRx = 1; step(9);
    sRx = 0; step(9);
    sIdWr = 1; sIdx = 4; sRdIdx = 4; sData = 32'hA000_0123; step(10); // R10 fields
    sEn = 32'h10; sIdWr = 1; sIdx = 4; sData = 32'h1234_5678; step(10); // R10 locked
    sEn = '0; sIdWr = 1; sIdx = 4; sData = 32'h5FFF_FFFF; step(10);
    sRdIdx = 7; step(10);
    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d expected items unchecked, exp 0", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule